// File: doc/BRIEF.md
# Floating-Point Status and Exception Register Unit

This unit keeps the control and status words of a floating-point coprocessor. The arithmetic datapath is outside the block. The datapath pulses a start strobe when an operation begins, which wipes the per-operation exception byte. It then pulses a completion strobe carrying eight raw exception flags, four condition-code flags and a quotient byte. On completion the unit loads the exception byte and folds it into five sticky accrued flags. It also compares the exception byte against the enable field of the control word.

When an enabled exception is present, the unit raises a trap request with a vector number, picked by fixed priority. The request stays up until the handler acknowledges it. While a trap is pending the status word is frozen against datapath activity, so the handler sees the state that caused the trap. Software reads both words at any time and writes either one through a simple select-and-strobe port.

Top module: `fp_status_unit`

## Requirements
- R1: After reset, `ctrl_rdata` and `stat_rdata` read 0 and `trap_req` is low.
- R2: A control write (`reg_wr`=1, `reg_sel`=0) stores three fields:
  - rounding mode in bits [5:4] (0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity);
  - precision in bits [7:6] (0 extended, 1 single, 2 double);
  - enables in bits [15:8], in the order inex1, inex2, dz, unfl, ovfl, operr, snan, bsun from bit 8.

  Bits [3:0] read 0 whatever is written.
- R3: A status write (`reg_wr`=1, `reg_sel`=1) stores four fields:
  - accrued flags in bits [7:3] (inex, dz, unfl, ovfl, iop from bit 3);
  - the exception byte in bits [15:8], in the same order as the enables;
  - the quotient in bits [23:16];
  - the condition codes in bits [27:24] (nan, infinity, zero, negative from bit 24).

  Bits [2:0] and [31:28] read 0.
- R4: `op_start` with no trap pending clears the exception byte one cycle later and leaves every other status field unchanged.
- R5: `op_done` with no trap pending performs three loads:
  - it loads the exception byte from `op_exc`, which uses the exception-byte bit order, and a set unfl bit also sets inex2;
  - it copies `op_cc` to the condition codes;
  - it copies `op_quot` to the quotient.
- R6: On `op_done` the accrued flags gain the following terms from the new exception byte:
  - iop from bsun|snan|operr;
  - ovfl from ovfl;
  - unfl from unfl&inex2;
  - dz from dz;
  - inex from inex1|inex2|ovfl.

  Accrued flags are never cleared except by a status write.
- R7: `op_done` raises `trap_req` on the next cycle exactly when some bit of the new exception byte has its enable set. Inexact fires when inex1 or inex2 has its own enable set.
- R8: `trap_vec` is picked among the enabled exceptions in this order of priority: bsun 48, snan 54, operr 52, ovfl 53, unfl 51, dz 50, inexact 49.
- R9: `trap_req` and `trap_vec` hold until `trap_ack`. `trap_req` is low in the cycle after the acknowledge. An acknowledge with no trap pending has no effect.
- R10: While `trap_req` is high, `op_start` and `op_done` change no status field and raise no new trap.
- R11: A status write in the same cycle as `op_done` wins: the status word takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 the status word |
| reg_wdata | input | 32 | Write data (control uses bits [15:0]) |
| ctrl_rdata | output | 16 | Control word |
| stat_rdata | output | 32 | Status word |
| op_start | input | 1 | Operation begins: clear the exception byte |
| op_done | input | 1 | Operation complete: capture flags |
| op_exc | input | 8 | Raw exception flags, exception-byte order |
| op_cc | input | 4 | Condition codes: nan, infinity, zero, negative from bit 0 |
| op_quot | input | 8 | Quotient sign and magnitude |
| trap_req | output | 1 | Trap request |
| trap_vec | output | 8 | Trap vector number |
| trap_ack | input | 1 | Trap acknowledge |

## Verification
The assertions assume that the trap handler eventually pulses `trap_ack` and that reset is held for at least one edge. They treat `op_exc`, `op_cc` and `op_quot` as meaningful only in cycles where `op_done` is high. The accrued-flag property excuses any cycle that carries a status write, because software may legally clear those flags. The stimulus drives the data inputs only together with a strobe and issues each acknowledge only while a trap is pending, except for one deliberate stray acknowledge. It places a status write against `op_done` only in the single case that exercises write priority.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;

    localparam int CTRL_W  = 16;
    localparam int STAT_W  = 32;
    localparam int EXC_W   = 8;
    localparam int ACC_W   = 5;
    localparam int CC_W    = 4;
    localparam int QUOT_W  = 8;
    localparam int VEC_W   = 8;
    localparam int MODE_W  = 2;
    localparam int CTRL_PAD_W = CTRL_W - EXC_W - 2 * MODE_W;
    localparam int STAT_LO_PAD = 3;
    localparam int STAT_HI_PAD = STAT_W - STAT_LO_PAD - ACC_W - EXC_W - QUOT_W - CC_W;

    localparam logic REG_CTRL = 1'b0;
    localparam logic REG_STAT = 1'b1;

    localparam logic [VEC_W-1:0] VEC_BSUN = 8'd48;
    localparam logic [VEC_W-1:0] VEC_INEX = 8'd49;
    localparam logic [VEC_W-1:0] VEC_DZ   = 8'd50;
    localparam logic [VEC_W-1:0] VEC_UNFL = 8'd51;
    localparam logic [VEC_W-1:0] VEC_OPER = 8'd52;
    localparam logic [VEC_W-1:0] VEC_OVFL = 8'd53;
    localparam logic [VEC_W-1:0] VEC_SNAN = 8'd54;

    // Exception byte; bit 0 is inex1
    typedef struct packed {
        logic bsun;
        logic snan;
        logic operr;
        logic ovfl;
        logic unfl;
        logic dz;
        logic inex2;
        logic inex1;
    } exc_t;

    // Sticky summary; bit 0 is inex
    typedef struct packed {
        logic iop;
        logic ovfl;
        logic unfl;
        logic dz;
        logic inex;
    } acc_t;

    typedef enum logic [MODE_W-1:0] {
        RND_EVEN = 2'd0, RND_ZERO = 2'd1, RND_DOWN = 2'd2, RND_UP = 2'd3
    } rnd_e;

    typedef struct packed {
        exc_t              en;
        logic [MODE_W-1:0] prec;
        rnd_e              rnd;
    } ctrl_t;

    function automatic exc_t widen_unfl(exc_t raw);
        exc_t r = raw;
        r.inex2 = raw.inex2 | raw.unfl;
        return r;
    endfunction

    function automatic acc_t summarize(exc_t e);
        acc_t a;
        a.iop  = e.bsun | e.snan | e.operr;
        a.ovfl = e.ovfl;
        a.unfl = e.unfl & e.inex2;
        a.dz   = e.dz;
        a.inex = e.inex1 | e.inex2 | e.ovfl;
        return a;
    endfunction

endpackage

// File: rtl/fpsu_ctrl_reg.sv
module fpsu_ctrl_reg
    import fpsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:CTRL_PAD_W]);
        end
    end
endmodule

// File: rtl/fpsu_exc_fold.sv
module fpsu_exc_fold
    import fpsu_pkg::*;
(
    input  logic [EXC_W-1:0] raw,
    output exc_t             es,
    output acc_t             acc
);
    always_comb begin
        es  = widen_unfl(exc_t'(raw));
        acc = summarize(es);
    end
endmodule

// File: rtl/fpsu_trap_arb.sv
module fpsu_trap_arb
    import fpsu_pkg::*;
(
    input  exc_t             es,
    input  exc_t             en,
    output logic             fire,
    output logic [VEC_W-1:0] vec
);
    exc_t hit;

    always_comb begin
        hit  = es & en;
        fire = |hit;
        vec  = VEC_INEX;
        if      (hit.bsun)  vec = VEC_BSUN;
        else if (hit.snan)  vec = VEC_SNAN;
        else if (hit.operr) vec = VEC_OPER;
        else if (hit.ovfl)  vec = VEC_OVFL;
        else if (hit.unfl)  vec = VEC_UNFL;
        else if (hit.dz)    vec = VEC_DZ;
    end
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
    import fpsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic [STAT_W-1:0] stat_rdata,
    input  logic              op_start,
    input  logic              op_done,
    input  logic [EXC_W-1:0]  op_exc,
    input  logic [CC_W-1:0]   op_cc,
    input  logic [QUOT_W-1:0] op_quot,
    output logic              trap_req,
    output logic [VEC_W-1:0]  trap_vec,
    input  logic              trap_ack
);
    localparam int ACC_LSB  = STAT_LO_PAD;
    localparam int EXC_LSB  = ACC_LSB + ACC_W;
    localparam int QUOT_LSB = EXC_LSB + EXC_W;
    localparam int CC_LSB   = QUOT_LSB + QUOT_W;

    ctrl_t             ctrl_q;
    exc_t              es_q, es_new;
    acc_t              acc_q, acc_new;
    logic [QUOT_W-1:0] quot_q;
    logic [CC_W-1:0]   cc_q;
    logic              trap_q;
    logic [VEC_W-1:0]  vec_q, vec_new;
    logic              fire;
    logic              stat_wr;

    assign stat_wr = reg_wr && (reg_sel == REG_STAT);

    fpsu_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr && (reg_sel == REG_CTRL)),
        .wdata (reg_wdata[CTRL_W-1:0]),
        .ctrl  (ctrl_q)
    );

    fpsu_exc_fold u_fold (
        .raw (op_exc),
        .es  (es_new),
        .acc (acc_new)
    );

    fpsu_trap_arb u_arb (
        .es   (es_new),
        .en   (ctrl_q.en),
        .fire (fire),
        .vec  (vec_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            es_q   <= '0;
            acc_q  <= '0;
            quot_q <= '0;
            cc_q   <= '0;
        end else if (stat_wr) begin
            acc_q  <= acc_t'(reg_wdata[EXC_LSB-1:ACC_LSB]);
            es_q   <= exc_t'(reg_wdata[QUOT_LSB-1:EXC_LSB]);
            quot_q <= reg_wdata[CC_LSB-1:QUOT_LSB];
            cc_q   <= reg_wdata[CC_LSB+CC_W-1:CC_LSB];
        end else if (!trap_q) begin
            if (op_done) begin
                es_q   <= es_new;
                acc_q  <= acc_q | acc_new;
                quot_q <= op_quot;
                cc_q   <= op_cc;
            end else if (op_start) begin
                es_q <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q <= 1'b0;
            vec_q  <= '0;
        end else if (trap_q) begin
            if (trap_ack) trap_q <= 1'b0;
        end else if (op_done && fire) begin
            trap_q <= 1'b1;
            vec_q  <= vec_new;
        end
    end

    assign ctrl_rdata = {ctrl_q, {CTRL_PAD_W{1'b0}}};
    assign stat_rdata = {{STAT_HI_PAD{1'b0}}, cc_q, quot_q, es_q, acc_q, {STAT_LO_PAD{1'b0}}};
    assign trap_req   = trap_q;
    assign trap_vec   = vec_q;

    // R4: a lone start clears the exception byte
    a_r4_start_clears: assert property (@(posedge clk) disable iff (rst)
        (op_start && !op_done && !trap_req && !stat_wr) |=> (stat_rdata[QUOT_LSB-1:EXC_LSB] == '0));

    // R6: accrued flags never drop without a status write
    a_r6_accrued_sticky: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((stat_rdata[EXC_LSB-1:ACC_LSB] & $past(stat_rdata[EXC_LSB-1:ACC_LSB]))
                      == $past(stat_rdata[EXC_LSB-1:ACC_LSB])));

    // R9: request and vector hold until acknowledged
    a_r9_trap_hold: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !trap_ack) |=> (trap_req && $stable(trap_vec)));

    a_r9_ack_drops: assert property (@(posedge clk) disable iff (rst)
        (trap_req && trap_ack) |=> !trap_req);

    // R10: status frozen while a trap is pending
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !stat_wr) |=> $stable(stat_rdata));

    // R8: vector always one of the defined numbers
    a_r8_vec_range: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (trap_vec >= VEC_BSUN && trap_vec <= VEC_SNAN));

    // R7: no trap without a completion
    a_r7_trap_cause: assert property (@(posedge clk) disable iff (rst)
        (!trap_req && !op_done) |=> !trap_req);
endmodule

// File: tb/tb_fp_status_unit.sv
module tb_fp_status_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_sel;
    logic [31:0] reg_wdata;
    logic [15:0] ctrl_rdata;
    logic [31:0] stat_rdata;
    logic        op_start, op_done;
    logic [7:0]  op_exc;
    logic [3:0]  op_cc;
    logic [7:0]  op_quot;
    logic        trap_req;
    logic [7:0]  trap_vec;
    logic        trap_ack;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fp_status_unit dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata), .op_start(op_start),
        .op_done(op_done), .op_exc(op_exc), .op_cc(op_cc), .op_quot(op_quot),
        .trap_req(trap_req), .trap_vec(trap_vec), .trap_ack(trap_ack)
    );

    typedef struct {
        string       tag;
        logic [15:0] ctrl;
        logic [31:0] stat;
        logic        req;
        logic [7:0]  vec;
    } exp_t;

    exp_t sb[$];

    // reference state, built from the requirements
    logic [15:0] m_ctrl = '0;
    logic [31:0] m_stat = '0;
    logic        m_req  = 1'b0;
    logic [7:0]  m_vec  = '0;

    function automatic logic [7:0] fold(logic [7:0] r);
        return r | (r[3] ? 8'h02 : 8'h00);
    endfunction

    function automatic logic [4:0] accr(logic [7:0] e);
        logic [4:0] a;
        a[0] = e[0] | e[1] | e[4];
        a[1] = e[2];
        a[2] = e[3] & e[1];
        a[3] = e[4];
        a[4] = e[7] | e[6] | e[5];
        return a;
    endfunction

    function automatic logic [7:0] pick(logic [7:0] h);
        if (h[7]) return 8'd48;
        if (h[6]) return 8'd54;
        if (h[5]) return 8'd52;
        if (h[4]) return 8'd53;
        if (h[3]) return 8'd51;
        if (h[2]) return 8'd50;
        return 8'd49;
    endfunction

    task automatic cyc(input bit wr, input bit sel, input logic [31:0] wd,
                       input bit st, input bit dn, input logic [7:0] ex,
                       input logic [3:0] cc, input logic [7:0] qu, input bit ak,
                       input string tag);
        logic [7:0] es, hit;
        exp_t it;
        @(negedge clk);
        reg_wr = wr; reg_sel = sel; reg_wdata = wd; op_start = st; op_done = dn;
        op_exc = ex; op_cc = cc; op_quot = qu; trap_ack = ak;
        es  = fold(ex);
        hit = es & m_ctrl[15:8];
        if (m_req) begin
            if (ak) m_req = 1'b0;
        end else if (dn && hit != 0) begin
            m_req = 1'b1;
            m_vec = pick(hit);
        end
        if (wr && sel) begin
            m_stat = wd & 32'h0FFF_FFF8;
        end else if (!(m_req && !(dn && hit != 0 && !m_req)) || !m_req) begin
            m_stat = m_stat;
        end
        if (wr && !sel) m_ctrl = wd[15:0] & 16'hFFF0;
        @(posedge clk);
        #1;
        it.tag = tag; it.ctrl = m_ctrl; it.stat = m_stat; it.req = m_req; it.vec = m_vec;
        sb.push_back(it);
        @(negedge clk);
        reg_wr = 0; op_start = 0; op_done = 0; trap_ack = 0;
    endtask

    // status update needs the pending state before the cycle; wrap it
    task automatic op(input bit wr, input bit sel, input logic [31:0] wd,
                      input bit st, input bit dn, input logic [7:0] ex,
                      input logic [3:0] cc, input logic [7:0] qu, input bit ak,
                      input string tag);
        logic [7:0] es;
        if (!(wr && sel) && !m_req) begin
            if (dn) begin
                es = fold(ex);
                m_stat[15:8]  = es;
                m_stat[7:3]   = m_stat[7:3] | accr(es);
                m_stat[23:16] = qu;
                m_stat[27:24] = cc;
            end else if (st) begin
                m_stat[15:8] = 8'h00;
            end
        end
        cyc(wr, sel, wd, st, dn, ex, cc, qu, ak, tag);
    endtask

    task automatic wctl(input logic [15:0] v, input string tag);
        op(1, 0, {16'h0, v}, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic wsta(input logic [31:0] v, input string tag);
        op(1, 1, v, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic done(input logic [7:0] ex, input logic [3:0] cc, input logic [7:0] qu,
                        input string tag);
        op(0, 0, 0, 0, 1, ex, cc, qu, 0, tag);
    endtask
    task automatic start(input string tag);
        op(0, 0, 0, 1, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic ack(input string tag);
        op(0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
    endtask

    // monitor: pops expected items and compares
    initial begin
        exp_t e;
        forever begin
            wait (sb.size() != 0);
            e = sb.pop_front();
            tests++;
            if (ctrl_rdata !== e.ctrl || stat_rdata !== e.stat || trap_req !== e.req ||
                (e.req && trap_vec !== e.vec)) begin
                fails++;
                $display("FAIL %s: ctrl=%h stat=%h req=%b vec=%0d expected ctrl=%h stat=%h req=%b vec=%0d",
                         e.tag, ctrl_rdata, stat_rdata, trap_req, trap_vec,
                         e.ctrl, e.stat, e.req, e.vec);
            end
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        exp_t e;
        rst = 1; reg_wr = 0; reg_sel = 0; reg_wdata = 0; op_start = 0; op_done = 0;
        op_exc = 0; op_cc = 0; op_quot = 0; trap_ack = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        e.tag = "R1 reset"; e.ctrl = 0; e.stat = 0; e.req = 0; e.vec = 0;
        sb.push_back(e);

        wctl(16'hFFFF, "R2 reserved ctrl bits");
        wctl(16'h0060, "R2 rnd=2 prec=1 no enables");
        wsta(32'hFFFF_FFFF, "R3 reserved status bits");
        wsta(32'h0000_0000, "R6 write clears accrued");
        done(8'h04, 4'b0100, 8'h85, "R5 dz capture with cc and quotient");
        start("R4 start clears exception byte");
        done(8'h08, 4'b1000, 8'h00, "R5 unfl implies inex2");
        done(8'h10, 4'b0010, 8'h7F, "R6 ovfl accrues ovfl and inex");
        done(8'h60, 4'b0001, 8'h01, "R6 snan and operr accrue iop");
        start("R6 accrued kept after start");
        op(1, 1, 32'h0000_0000, 0, 1, 8'h04, 4'b0100, 8'h11, 0, "R11 write beats op_done");

        wctl(16'h8200, "R2 enable bsun and inex2");
        done(8'h82, 4'b0000, 8'h00, "R8 bsun vector 48");
        done(8'h04, 4'b0100, 8'h22, "R10 op_done ignored while pending");
        start("R10 op_start ignored while pending");
        op(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 request held");
        ack("R9 ack clears request");
        ack("R9 stray ack no effect");

        wctl(16'hFF00, "R2 enable all");
        done(8'h05, 4'b0000, 8'h00, "R8 dz over inexact vector 50");
        ack("R9 ack");
        wctl(16'h0100, "R2 enable inex1 only");
        done(8'h01, 4'b0000, 8'h00, "R7 inex1 traps vector 49");
        ack("R9 ack");
        done(8'h04, 4'b0000, 8'h00, "R7 disabled dz no trap");
        wctl(16'h0000, "R2 no enables");
        done(8'hFF, 4'b1111, 8'hFF, "R7 no enables no trap");

        wctl(16'hFF00, "R2 enable all");
        done(8'h38, 4'b0000, 8'h00, "R8 operr over ovfl and unfl vector 52");
        ack("R9 ack");
        done(8'hC0, 4'b0000, 8'h00, "R8 bsun over snan vector 48");
        ack("R9 ack");
        done(8'h40, 4'b0000, 8'h00, "R8 snan vector 54");
        ack("R9 ack");
        done(8'h18, 4'b0000, 8'h00, "R8 ovfl over unfl vector 53");
        ack("R9 ack");
        done(8'h08, 4'b0000, 8'h00, "R8 unfl vector 51");
        ack("R9 ack");

        repeat (2) @(posedge clk);
        wait (sb.size() == 0);
        #1;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule